// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block predicts the value returned by a pointer load when that load misses in the L2 cache while the core is running ahead. It relies on the fact that many pointer loads show a fixed distance between the address they read and the pointer they return. This happens when linked nodes are allocated at a regular stride, or when a node and the object it points to are allocated side by side. The block keeps that distance per load PC. The distance, here called the delta, is the effective address minus the loaded value, taken modulo 2^ADDR_W.

The retirement stage drives the training port with the PC, effective address and loaded value of each load that retires in normal mode. A load whose delta magnitude is not below the MAX_AVD window is taken to carry plain data, and the block drops it. The runahead pipeline drives the lookup port when a load misses in L2. One cycle later the block returns a predicted value, but only for an entry whose confidence is saturated. A wrong prediction needs no repair of any state, because everything done while running ahead is discarded anyway.

Top module: `avd_predictor`

## Requirements
- R1: Reset clears every entry. While reset is held, and on the first lookup after it, predValid is 0.
- R2: The delta is trainAddr minus trainValue, taken modulo 2^ADDR_W. A prediction returns lookupAddr minus the stored delta sign-extended to ADDR_W bits, also modulo 2^ADDR_W, so negative deltas and wrap-around both work.
- R3: A training request is accepted only when the signed delta lies strictly between -MAX_AVD and +MAX_AVD (default 65536). A delta of exactly -MAX_AVD or +MAX_AVD, or any larger magnitude, changes no entry, no confidence and no replacement order.
- R4: A newly allocated entry starts with confidence 0. Each training whose delta equals the stored one adds 1 to the 2-bit confidence, saturating at 3. A prediction is made only at confidence 3, so four consistent trainings are needed.
- R5: A training that hits an entry with a different delta stores the new delta and clears the confidence to 0. Prediction stops until three further matching trainings have been made.
- R6: predValid and predValue are registered and reflect the lookup of the previous cycle. With lookupValid low the next predValid is 0, and predValue is 0 whenever predValid is 0.
- R7: PC bits [SET_W-1:0] (SET_W = 2 by default) select the set, and the remaining PC bits form the tag. A PC that shares a set with a trained PC but has a different tag gets no prediction.
- R8: Each set holds NUM_WAYS (4) entries with least-recently-trained replacement. A training that hits, or that allocates, makes its entry the most recent one. A training that misses in a full set evicts the least recent entry.
- R9: When a training and a lookup arrive in the same cycle, the lookup sees the table as it was before that training.
- R10: A training changes only the one entry it selects. Entries in other sets keep their predictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trainValid | input | 1 | A normal-mode load is retiring |
| trainPc | input | PC_W | PC of the retiring load |
| trainAddr | input | ADDR_W | Effective address of the retiring load |
| trainValue | input | ADDR_W | Value loaded by the retiring load |
| lookupValid | input | 1 | A runahead load missed in L2 |
| lookupPc | input | PC_W | PC of the missing load |
| lookupAddr | input | ADDR_W | Effective address of the missing load |
| predValid | output | 1 | A confident prediction is available |
| predValue | output | ADDR_W | Predicted loaded value, 0 when predValid is low |

## Verification
The table is driven with a strided traversal whose delta is negative, and with a wrapping pair whose address sits near zero while its value sits near the top of the address space. The two patterns show whether the sign extension of the stored delta and the modular subtraction are correct. Training loads whose deltas sit exactly on each window edge, and then one unit inside it, separates a strict bound from an inclusive one. Interleaving these with lookups at confidence 2 and 3 shows whether prediction waits for saturation. Training five PCs into one set shows whether the victim is chosen by training order. A training and a lookup issued together show whether the lookup reads the table before or after the write.

// File: rtl/avd_pkg.sv
`timescale 1ns/1ps
package avd_pkg;

  // Strobes from the control to the datapath for one table write
  typedef struct packed {
    logic wrEn;       // write the selected entry this cycle
    logic loadTag;    // allocate: set valid and the tag
    logic loadDelta;  // store the incoming delta
    logic bumpConf;   // 1: saturating increment, 0: clear confidence
  } avd_strobe_t;

  function automatic int unsigned idxWidth(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/avd_datapath.sv
`timescale 1ns/1ps
module avd_datapath
  import avd_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned CONF_W   = 2,
  parameter int unsigned MAX_AVD  = 65536
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PC_W-1:0]               trainPc,
  input  logic [ADDR_W-1:0]             trainAddr,
  input  logic [ADDR_W-1:0]             trainValue,
  input  logic                          lookupValid,
  input  logic [PC_W-1:0]               lookupPc,
  input  logic [ADDR_W-1:0]             lookupAddr,
  input  avd_strobe_t                   stb,
  input  logic [idxWidth(NUM_WAYS)-1:0] wrWay,
  output logic [idxWidth(NUM_SETS)-1:0] trainSet,
  output logic [NUM_WAYS-1:0]           trainHitVec,
  output logic [NUM_WAYS-1:0]           deltaEqVec,
  output logic                          inRange,
  output logic                          predValid,
  output logic [ADDR_W-1:0]             predValue
);

  localparam int unsigned SET_W   = idxWidth(NUM_SETS);
  localparam int unsigned TAG_W   = PC_W - SET_W;
  localparam int unsigned DELTA_W = $clog2(MAX_AVD) + 1;
  localparam logic [CONF_W-1:0] CONF_MAX  = '1;
  localparam logic [ADDR_W-1:0] AVD_LIMIT = ADDR_W'(MAX_AVD);

  // Table storage
  logic               entryValid [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0]   entryTag   [NUM_SETS][NUM_WAYS];
  logic [DELTA_W-1:0] entryDelta [NUM_SETS][NUM_WAYS];
  logic [CONF_W-1:0]  entryConf  [NUM_SETS][NUM_WAYS];

  // Training side: delta and window filter
  logic [ADDR_W-1:0]  trainDiff;
  logic [ADDR_W-1:0]  diffMag;
  logic [DELTA_W-1:0] newDelta;
  logic [TAG_W-1:0]   trainTag;

  assign trainDiff = trainAddr - trainValue;
  assign diffMag   = trainDiff[ADDR_W-1] ? (~trainDiff + ADDR_W'(1)) : trainDiff;
  assign inRange   = diffMag < AVD_LIMIT;
  assign newDelta  = trainDiff[DELTA_W-1:0];
  assign trainSet  = trainPc[SET_W-1:0];
  assign trainTag  = trainPc[PC_W-1:SET_W];

  // Lookup side
  logic [SET_W-1:0]    lookSet;
  logic [TAG_W-1:0]    lookTag;
  logic [NUM_WAYS-1:0] lookMatch;
  logic                lookReady;
  logic [DELTA_W-1:0]  lookDelta;
  logic [ADDR_W-1:0]   extDelta;

  assign lookSet = lookupPc[SET_W-1:0];
  assign lookTag = lookupPc[PC_W-1:SET_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign trainHitVec[w] = entryValid[trainSet][w] && (entryTag[trainSet][w] == trainTag);
    assign deltaEqVec[w]  = (entryDelta[trainSet][w] == newDelta);
    assign lookMatch[w]   = entryValid[lookSet][w] && (entryTag[lookSet][w] == lookTag)
                            && (entryConf[lookSet][w] == CONF_MAX);
  end

  always_comb begin
    lookDelta = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      lookDelta = lookDelta | ({DELTA_W{lookMatch[w]}} & entryDelta[lookSet][w]);
    end
  end

  assign lookReady = |lookMatch;
  assign extDelta  = {{(ADDR_W-DELTA_W){lookDelta[DELTA_W-1]}}, lookDelta};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      predValid <= 1'b0;
      predValue <= '0;
    end else if (lookupValid && lookReady) begin
      predValid <= 1'b1;
      predValue <= lookupAddr - extDelta;
    end else begin
      predValid <= 1'b0;
      predValue <= '0;
    end
  end

  // Confidence next value for the written entry
  logic [CONF_W-1:0] curConf;
  logic [CONF_W-1:0] nextConf;

  assign curConf  = entryConf[trainSet][wrWay];
  assign nextConf = stb.bumpConf ? ((curConf == CONF_MAX) ? CONF_MAX : curConf + CONF_W'(1))
                                 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          entryValid[s][w] <= 1'b0;
          entryTag[s][w]   <= '0;
          entryDelta[s][w] <= '0;
          entryConf[s][w]  <= '0;
        end
      end
    end else if (stb.wrEn) begin
      if (stb.loadTag) begin
        entryValid[trainSet][wrWay] <= 1'b1;
        entryTag[trainSet][wrWay]   <= trainTag;
      end
      if (stb.loadDelta) begin
        entryDelta[trainSet][wrWay] <= newDelta;
      end
      entryConf[trainSet][wrWay] <= nextConf;
    end
  end

endmodule

// File: rtl/avd_ctrl.sv
`timescale 1ns/1ps
module avd_ctrl
  import avd_pkg::*;
#(
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trainValid,
  input  logic [idxWidth(NUM_SETS)-1:0] trainSet,
  input  logic [NUM_WAYS-1:0]           trainHitVec,
  input  logic [NUM_WAYS-1:0]           deltaEqVec,
  input  logic                          inRange,
  output avd_strobe_t                   stb,
  output logic [idxWidth(NUM_WAYS)-1:0] wrWay
);

  localparam int unsigned WAY_W = idxWidth(NUM_WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

  // Per-set recency ages: 0 is most recent, NUM_WAYS-1 is the victim
  logic [WAY_W-1:0] wayAge [NUM_SETS][NUM_WAYS];

  logic             hitAny;
  logic             deltaSame;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] victimWay;
  logic [WAY_W-1:0] touchedAge;

  assign hitAny    = |trainHitVec;
  assign deltaSame = |(trainHitVec & deltaEqVec);

  always_comb begin
    hitWay    = '0;
    victimWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (trainHitVec[w])                 hitWay    = WAY_W'(w);
      if (wayAge[trainSet][w] == OLDEST)  victimWay = WAY_W'(w);
    end
  end

  always_comb begin
    stb   = '0;
    wrWay = victimWay;
    if (trainValid && inRange) begin
      stb.wrEn = 1'b1;
      if (hitAny) begin
        wrWay         = hitWay;
        stb.bumpConf  = deltaSame;
        stb.loadDelta = !deltaSame;
      end else begin
        stb.loadTag   = 1'b1;
        stb.loadDelta = 1'b1;
      end
    end
  end

  assign touchedAge = wayAge[trainSet][wrWay];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          wayAge[s][w] <= WAY_W'(w);
        end
      end
    end else if (stb.wrEn) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == wrWay) begin
          wayAge[trainSet][w] <= '0;
        end else if (wayAge[trainSet][w] < touchedAge) begin
          wayAge[trainSet][w] <= wayAge[trainSet][w] + WAY_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/avd_predictor.sv
`timescale 1ns/1ps
module avd_predictor
  import avd_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned CONF_W   = 2,
  parameter int unsigned MAX_AVD  = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trainValid,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [ADDR_W-1:0] trainAddr,
  input  logic [ADDR_W-1:0] trainValue,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              predValid,
  output logic [ADDR_W-1:0] predValue
);

  localparam int unsigned SET_W = idxWidth(NUM_SETS);
  localparam int unsigned WAY_W = idxWidth(NUM_WAYS);

  avd_strobe_t         stb;
  logic [WAY_W-1:0]    wrWay;
  logic [SET_W-1:0]    trainSet;
  logic [NUM_WAYS-1:0] trainHitVec;
  logic [NUM_WAYS-1:0] deltaEqVec;
  logic                inRange;

  avd_ctrl #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trainValid  (trainValid),
    .trainSet    (trainSet),
    .trainHitVec (trainHitVec),
    .deltaEqVec  (deltaEqVec),
    .inRange     (inRange),
    .stb         (stb),
    .wrWay       (wrWay)
  );

  avd_datapath #(
    .PC_W     (PC_W),
    .ADDR_W   (ADDR_W),
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .CONF_W   (CONF_W),
    .MAX_AVD  (MAX_AVD)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trainPc     (trainPc),
    .trainAddr   (trainAddr),
    .trainValue  (trainValue),
    .lookupValid (lookupValid),
    .lookupPc    (lookupPc),
    .lookupAddr  (lookupAddr),
    .stb         (stb),
    .wrWay       (wrWay),
    .trainSet    (trainSet),
    .trainHitVec (trainHitVec),
    .deltaEqVec  (deltaEqVec),
    .inRange     (inRange),
    .predValid   (predValid),
    .predValue   (predValue)
  );

endmodule

// File: rtl/avd_predictor_chk.sv
`timescale 1ns/1ps
module avd_predictor_chk
  import avd_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned ADDR_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trainValid,
  input logic                lookupValid,
  input logic                predValid,
  input logic [ADDR_W-1:0]   predValue,
  input logic                inRange,
  input avd_strobe_t         stb,
  input logic [NUM_WAYS-1:0] trainHitVec
);

  AST_RESET_NO_PRED: assert property (@(posedge clk) !rst_n |=> !predValid); // R1

  AST_IDLE_LOOKUP_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !predValid); // R6

  AST_INVALID_VALUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !predValid |-> (predValue == '0)); // R6

  AST_WINDOW_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (trainValid && !inRange) |-> !stb.wrEn); // R3

  AST_NO_TRAIN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !trainValid |-> !stb.wrEn); // R10

  AST_SINGLE_TAG_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trainHitVec)); // R7

  AST_MISS_ALLOCATES: assert property (@(posedge clk) disable iff (!rst_n)
    (trainValid && inRange && (trainHitVec == '0)) |-> (stb.wrEn && stb.loadTag)); // R8

endmodule

bind avd_predictor avd_predictor_chk #(
  .NUM_WAYS (NUM_WAYS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .trainValid  (trainValid),
  .lookupValid (lookupValid),
  .predValid   (predValid),
  .predValue   (predValue),
  .inRange     (inRange),
  .stb         (stb),
  .trainHitVec (trainHitVec)
);

// File: tb/avd_predictor_tb_top.sv
`timescale 1ns/1ps
module avd_predictor_tb_top;

  logic        clk;
  logic        rst_n;
  logic        trainValid;
  logic [31:0] trainPc;
  logic [31:0] trainAddr;
  logic [31:0] trainValue;
  logic        lookupValid;
  logic [31:0] lookupPc;
  logic [31:0] lookupAddr;
  logic        predValid;
  logic [31:0] predValue;

  int checks   = 0;
  int failures = 0;

  avd_predictor dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trainValid  (trainValid),
    .trainPc     (trainPc),
    .trainAddr   (trainAddr),
    .trainValue  (trainValue),
    .lookupValid (lookupValid),
    .lookupPc    (lookupPc),
    .lookupAddr  (lookupAddr),
    .predValid   (predValid),
    .predValue   (predValue)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        isTrain;
    logic [23:0] req;
    logic [31:0] pc;
    logic [31:0] addr;
    logic [31:0] value;
    logic        expValid;
    logic [31:0] expValue;
  } vec_t;

  localparam int NUM_VECS = 23;
  localparam logic [31:0] PC_A = 32'h100;  // set 0
  localparam logic [31:0] PC_B = 32'h201;  // set 1

  localparam vec_t VECS [NUM_VECS] = '{
    '{1'b1, "R4 ", PC_A,     32'h1000,  32'h1020,     1'b0, 32'h0},
    '{1'b1, "R4 ", PC_A,     32'h1020,  32'h1040,     1'b0, 32'h0},
    '{1'b1, "R4 ", PC_A,     32'h1040,  32'h1060,     1'b0, 32'h0},
    '{1'b0, "R4 ", PC_A,     32'h5000,  32'h0,        1'b0, 32'h0},
    '{1'b1, "R4 ", PC_A,     32'h1060,  32'h1080,     1'b0, 32'h0},
    '{1'b0, "R2 ", PC_A,     32'h5000,  32'h0,        1'b1, 32'h5020},
    '{1'b0, "R7 ", 32'h104,  32'h5000,  32'h0,        1'b0, 32'h0},
    '{1'b1, "R3 ", PC_A,     32'h0,     32'h10000,    1'b0, 32'h0},
    '{1'b0, "R3 ", PC_A,     32'h7000,  32'h0,        1'b1, 32'h7020},
    '{1'b1, "R3 ", PC_A,     32'h10000, 32'h0,        1'b0, 32'h0},
    '{1'b0, "R3 ", PC_A,     32'h7000,  32'h0,        1'b1, 32'h7020},
    '{1'b1, "R5 ", PC_A,     32'hFFFF,  32'h0,        1'b0, 32'h0},
    '{1'b0, "R5 ", PC_A,     32'h7000,  32'h0,        1'b0, 32'h0},
    '{1'b1, "R5 ", PC_A,     32'h1FFFF, 32'h10000,    1'b0, 32'h0},
    '{1'b1, "R5 ", PC_A,     32'h1FFFF, 32'h10000,    1'b0, 32'h0},
    '{1'b0, "R5 ", PC_A,     32'h20000, 32'h0,        1'b0, 32'h0},
    '{1'b1, "R5 ", PC_A,     32'h1FFFF, 32'h10000,    1'b0, 32'h0},
    '{1'b0, "R3 ", PC_A,     32'h20000, 32'h0,        1'b1, 32'h10001},
    '{1'b1, "R2 ", PC_B,     32'h8,     32'hFFFFFFF8, 1'b0, 32'h0},
    '{1'b1, "R2 ", PC_B,     32'h8,     32'hFFFFFFF8, 1'b0, 32'h0},
    '{1'b1, "R2 ", PC_B,     32'h8,     32'hFFFFFFF8, 1'b0, 32'h0},
    '{1'b1, "R2 ", PC_B,     32'h8,     32'hFFFFFFF8, 1'b0, 32'h0},
    '{1'b0, "R2 ", PC_B,     32'h4,     32'h0,        1'b1, 32'hFFFFFFF4}
  };

  task automatic check(input string req, input logic expV, input logic [31:0] expVal);
    checks++;
    if (predValid !== expV || predValue !== expVal) begin
      failures++;
      $display("FAIL %s: got valid=%0b value=%h, expected valid=%0b value=%h",
               req, predValid, predValue, expV, expVal);
    end
  endtask

  // Called at a falling edge; drives one cycle and returns at the next falling edge
  task automatic cycle(input logic tv, input logic [31:0] tpc, input logic [31:0] ta,
                       input logic [31:0] tval, input logic lv, input logic [31:0] lpc,
                       input logic [31:0] la);
    trainValid  = tv;
    trainPc     = tpc;
    trainAddr   = ta;
    trainValue  = tval;
    lookupValid = lv;
    lookupPc    = lpc;
    lookupAddr  = la;
    @(negedge clk);
    trainValid  = 1'b0;
    lookupValid = 1'b0;
  endtask

  task automatic trainN(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] v,
                        input int n);
    for (int i = 0; i < n; i++) cycle(1'b1, pc, a, v, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic lookup(input logic [31:0] pc, input logic [31:0] a);
    cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, pc, a);
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    trainValid = 1'b0; trainPc = '0; trainAddr = '0; trainValue = '0;
    lookupValid = 1'b0; lookupPc = '0; lookupAddr = '0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 32'h0);
    rst_n = 1'b1;
    lookup(PC_A, 32'h5000);
    check("R1", 1'b0, 32'h0);

    // Vector walk
    for (int i = 0; i < NUM_VECS; i++) begin
      cycle(VECS[i].isTrain, VECS[i].pc, VECS[i].addr, VECS[i].value,
            !VECS[i].isTrain, VECS[i].pc, VECS[i].addr);
      check($sformatf("%s vec%0d", VECS[i].req, i), VECS[i].expValid, VECS[i].expValue);
    end

    // R6: lookup strobe low with a confident PC on the bus
    cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b0, PC_A, 32'h20000);
    check("R6", 1'b0, 32'h0);

    // R9: same-cycle training (new delta 0x40) and lookup sees the old delta
    cycle(1'b1, PC_A, 32'h40, 32'h0, 1'b1, PC_A, 32'h20000);
    check("R9", 1'b1, 32'h10001);
    lookup(PC_A, 32'h20000);
    check("R9", 1'b0, 32'h0);

    // R8: five PCs in set 2, delta 8; retouch the first, then allocate the fifth
    trainN(32'h2, 32'h100, 32'hF8, 4);
    trainN(32'h6, 32'h100, 32'hF8, 4);
    trainN(32'hA, 32'h100, 32'hF8, 4);
    trainN(32'hE, 32'h100, 32'hF8, 4);
    trainN(32'h2, 32'h100, 32'hF8, 1);
    trainN(32'h12, 32'h100, 32'hF8, 1);
    lookup(32'h2, 32'h300);  check("R8 kept", 1'b1, 32'h2F8);
    lookup(32'h6, 32'h300);  check("R8 evicted", 1'b0, 32'h0);
    lookup(32'hA, 32'h300);  check("R8 kept", 1'b1, 32'h2F8);
    lookup(32'hE, 32'h300);  check("R8 kept", 1'b1, 32'h2F8);
    lookup(32'h12, 32'h300); check("R8 new", 1'b0, 32'h0);

    // R10: set 1 entry untouched by all of the above
    lookup(PC_B, 32'h4);
    check("R10", 1'b1, 32'hFFFFFFF4);

    // R1: reset in mid-run clears the table
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", 1'b0, 32'h0);
    rst_n = 1'b1;
    lookup(PC_B, 32'h4);
    check("R1", 1'b0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule